// File: doc/BRIEF.md
# Timed Event Sequence Broadcaster

This block sits on the master side of a trigger distribution network. It holds two event tables in one on-chip memory. The run table drives a normal experiment. The shutdown table takes over when the run is aborted. Each table row pairs an 8-bit event code with a time offset. The offset is counted in coarse ticks from the moment the sequence was launched. With the default divider a tick is 1000 system clocks, which is 10 µs at 100 MHz. Offsets therefore count from launch and not from the experiment's zero instant, and events that fall before zero are simply small offsets.

A launch clears the tick counter and starts at row 0 of the chosen table. When a row's offset is reached, its code is pushed into a shared transmit FIFO, tagged with the set of enabled slave links, so that every connected slave receives it. The block then moves to the next row. A zero code ends a table. A full FIFO holds the pending row back without losing it, and raises a sticky lateness flag.

Top module: `evt_seq_bcast`

## Requirements
- R1: After synchronous reset, `busy`, `tx_push`, `late` and `in_shutdown` are all 0.
- R2: `start` sampled high at clock edge c while idle launches the run table (`in_shutdown`=0) from row 0, with the tick count at 0, and `busy` rises. A row with offset k reaches `tx_push` after edge c+2 if k=0, or after edge c+TICK_DIV*k+1 if k>0, unless the previous row's push is later than that.
- R3: Rows that share an offset are pushed in table order, two clocks apart. Each push is a single-cycle pulse.
- R4: A row whose code is 0x00 ends the table. `busy` falls and no further code is pushed until the next launch.
- R5: `abort` sampled high while idle, or during the run table, immediately launches the shutdown table (`in_shutdown`=1) from row 0, with the tick count at 0 and the same timing as R2. No remaining run-table row is pushed.
- R6: `start` is ignored while busy, and `abort` is ignored while the shutdown table runs. Neither alters the timing of the pushes.
- R7: While `tx_full` is high, nothing is pushed. A due row is held and pushed after `tx_full` falls, and `late` goes high. `late` stays high until the next launch clears it.
- R8: On every push, `tx_dest` equals `link_en` as it was in the cycle before the push, so the code is broadcast to every enabled link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Table write strobe |
| ld_tbl | input | 1 | Table written: 0 run, 1 shutdown |
| ld_idx | input | IDX_W | Row index written |
| ld_ofs | input | OFS_W | Tick offset of the row |
| ld_code | input | CODE_W | Event code of the row (0 ends the table) |
| link_en | input | LINKS | Connected slave links |
| start | input | 1 | Launch the run table |
| abort | input | 1 | Switch to the shutdown table |
| tx_full | input | 1 | Transmit FIFO full |
| tx_push | output | 1 | FIFO write strobe |
| tx_code | output | CODE_W | Event code pushed |
| tx_dest | output | LINKS | Links the code goes to |
| busy | output | 1 | A table is running |
| in_shutdown | output | 1 | Shutdown table selected |
| late | output | 1 | A due row waited on a full FIFO |

## Verification
The run table mixes rows at offset zero, pairs and triples that share an offset, and gaps of several ticks. The exact push cycle of each row therefore separates tick pacing (R2) from the two-clock fetch spacing within a tick (R3). A mid-run abort, followed by start and abort pulses during the shutdown table, shows that the switch discards the rest of the run table and that ignored commands leave the timing untouched. Launching with the FIFO already full tells a held row apart from a dropped one, and the next launch, an abort from idle, shows that the lateness flag clears and that `tx_dest` follows a changed link mask.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CHECK = 2'd2
  } seq_state_t;

  localparam logic TBL_RUN  = 1'b0;
  localparam logic TBL_SHUT = 1'b1;
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
  parameter int TICK_DIV = 1000,
  parameter int OFS_W    = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  output logic [OFS_W-1:0] tick_cnt
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_q    <= '0;
      tick_cnt <= '0;
    end else if (run) begin
      if (div_q == DIV_LAST) begin
        div_q    <= '0;
        tick_cnt <= tick_cnt + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/evt_seq_ram.sv
module evt_seq_ram #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evt_seq_fsm.sv
module evt_seq_fsm
  import evt_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int OFS_W  = 24,
  parameter int CODE_W = 8,
  parameter int LINKS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  input  logic              tx_full,
  input  logic [LINKS-1:0]  link_en,
  input  logic [OFS_W-1:0]  tick_cnt,
  input  logic [OFS_W-1:0]  ent_ofs,
  input  logic [CODE_W-1:0] ent_code,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              tbl_sel,
  output logic              tick_clear,
  output logic              busy,
  output logic              tx_push,
  output logic [CODE_W-1:0] tx_code,
  output logic [LINKS-1:0]  tx_dest,
  output logic              late
);
  seq_state_t state_q;
  logic       go_run, go_shut, due;

  assign busy       = (state_q != ST_IDLE);
  assign go_shut    = abort && !(busy && tbl_sel == TBL_SHUT);
  assign go_run     = start && !busy && !go_shut;
  assign tick_clear = go_run || go_shut;
  assign due        = (ent_ofs <= tick_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rd_idx  <= '0;
      tbl_sel <= TBL_RUN;
      tx_push <= 1'b0;
      tx_code <= '0;
      tx_dest <= '0;
      late    <= 1'b0;
    end else begin
      tx_push <= 1'b0;
      if (go_shut || go_run) begin
        tbl_sel <= go_shut ? TBL_SHUT : TBL_RUN;
        rd_idx  <= '0;
        late    <= 1'b0;
        state_q <= ST_READ;
      end else begin
        unique case (state_q)
          ST_READ: state_q <= ST_CHECK;
          ST_CHECK: begin
            if (ent_code == '0) begin
              state_q <= ST_IDLE;
            end else if (due) begin
              if (tx_full) begin
                late <= 1'b1;
              end else begin
                tx_push <= 1'b1;
                tx_code <= ent_code;
                tx_dest <= link_en;
                rd_idx  <= rd_idx + 1'b1;
                state_q <= ST_READ;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/evt_seq_bcast.sv
module evt_seq_bcast #(
  parameter int TICK_DIV = 1000,
  parameter int IDX_W    = 8,
  parameter int OFS_W    = 24,
  parameter int CODE_W   = 8,
  parameter int LINKS    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_tbl,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [OFS_W-1:0]  ld_ofs,
  input  logic [CODE_W-1:0] ld_code,
  input  logic [LINKS-1:0]  link_en,
  input  logic              start,
  input  logic              abort,
  input  logic              tx_full,
  output logic              tx_push,
  output logic [CODE_W-1:0] tx_code,
  output logic [LINKS-1:0]  tx_dest,
  output logic              busy,
  output logic              in_shutdown,
  output logic              late
);
  localparam int AW = IDX_W + 1;
  localparam int DW = OFS_W + CODE_W;

  logic [OFS_W-1:0]  tick_cnt;
  logic              tick_clear;
  logic [IDX_W-1:0]  rd_idx;
  logic              tbl_sel;
  logic [DW-1:0]     rd_word;

  evt_tick_gen #(.TICK_DIV(TICK_DIV), .OFS_W(OFS_W)) u_tick (
    .clk(clk), .rst(rst), .clear(tick_clear), .run(busy), .tick_cnt(tick_cnt)
  );

  evt_seq_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(ld_we), .waddr({ld_tbl, ld_idx}), .wdata({ld_ofs, ld_code}),
    .raddr({tbl_sel, rd_idx}), .rdata(rd_word)
  );

  evt_seq_fsm #(.IDX_W(IDX_W), .OFS_W(OFS_W), .CODE_W(CODE_W), .LINKS(LINKS)) u_fsm (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .tx_full(tx_full),
    .link_en(link_en), .tick_cnt(tick_cnt),
    .ent_ofs(rd_word[DW-1:CODE_W]), .ent_code(rd_word[CODE_W-1:0]),
    .rd_idx(rd_idx), .tbl_sel(tbl_sel), .tick_clear(tick_clear), .busy(busy),
    .tx_push(tx_push), .tx_code(tx_code), .tx_dest(tx_dest), .late(late)
  );

  assign in_shutdown = tbl_sel;
endmodule

// File: rtl/evt_seq_bcast_chk.sv
module evt_seq_bcast_chk #(
  parameter int CODE_W = 8,
  parameter int LINKS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              abort,
  input logic              tx_full,
  input logic [LINKS-1:0]  link_en,
  input logic              tx_push,
  input logic [CODE_W-1:0] tx_code,
  input logic [LINKS-1:0]  tx_dest,
  input logic              busy,
  input logic              in_shutdown,
  input logic              late
);
  a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> !$past(tx_full));
  a_r4_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tx_push);
  a_r4_no_sentinel_push: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> tx_code != '0);
  a_r8_broadcast: assert property (@(posedge clk) disable iff (rst)
    tx_push |-> tx_dest == $past(link_en));
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_push |=> !tx_push);
  a_r7_late_sticky: assert property (@(posedge clk) disable iff (rst)
    late && !start && !abort |=> late);
  a_r5_abort_switch: assert property (@(posedge clk) disable iff (rst)
    busy && !in_shutdown && abort |=> in_shutdown && busy);
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    busy && in_shutdown && start |=> in_shutdown);
endmodule

bind evt_seq_bcast evt_seq_bcast_chk #(.CODE_W(CODE_W), .LINKS(LINKS)) u_chk (
  .clk(clk), .rst(rst), .start(start), .abort(abort), .tx_full(tx_full),
  .link_en(link_en), .tx_push(tx_push), .tx_code(tx_code), .tx_dest(tx_dest),
  .busy(busy), .in_shutdown(in_shutdown), .late(late)
);

// File: tb/evt_seq_bcast_tb.sv
module evt_seq_bcast_tb;
  localparam int TD = 20, IW = 4, OW = 16, CW = 8, LK = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic ld_we = 0, ld_tbl = 0;
  logic [IW-1:0] ld_idx = '0;
  logic [OW-1:0] ld_ofs = '0;
  logic [CW-1:0] ld_code = '0;
  logic [LK-1:0] link_en = 8'hFF;
  logic start = 0, abort = 0, tx_full = 0;
  logic tx_push, busy, in_shutdown, late;
  logic [CW-1:0] tx_code;
  logic [LK-1:0] tx_dest;

  evt_seq_bcast #(.TICK_DIV(TD), .IDX_W(IW), .OFS_W(OW), .CODE_W(CW), .LINKS(LK)) u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_tbl(ld_tbl), .ld_idx(ld_idx),
    .ld_ofs(ld_ofs), .ld_code(ld_code), .link_en(link_en), .start(start),
    .abort(abort), .tx_full(tx_full), .tx_push(tx_push), .tx_code(tx_code),
    .tx_dest(tx_dest), .busy(busy), .in_shutdown(in_shutdown), .late(late)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, ncnt = 0, pushes = 0, t0 = 0;
  int q_time[$];
  logic [CW-1:0] q_code[$];
  string q_req[$];

  int run_ofs[6]  = '{0, 0, 2, 5, 5, 5};
  logic [CW-1:0] run_code[6] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
  int shut_ofs[4] = '{0, 1, 1, 3};
  logic [CW-1:0] shut_code[4] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    ncnt++;
    if (!rst && tx_push) begin
      pushes++;
      if (q_code.size() == 0) begin
        check(0, "R4 unexpected push", int'(tx_code), 0);
      end else begin
        logic [CW-1:0] ec;
        int et;
        string er;
        ec = q_code.pop_front();
        et = q_time.pop_front();
        er = q_req.pop_front();
        check(tx_code == ec, {er, " code"}, int'(tx_code), int'(ec));
        if (et >= 0) check(ncnt == et, {er, " push cycle"}, ncnt, et);
        check(tx_dest == link_en, "R8 dest", int'(tx_dest), int'(link_en));
      end
    end
  end

  task automatic load(input bit tbl, input int idx, input int ofs, input logic [CW-1:0] code);
    @(negedge clk); #1;
    ld_we = 1; ld_tbl = tbl; ld_idx = IW'(idx); ld_ofs = OW'(ofs); ld_code = code;
    @(negedge clk); #1;
    ld_we = 0;
  endtask

  // driver: expected items go to the queue
  task automatic expect_table(input bit tbl, input bit timed);
    int chk, p, tk, n, o, prev;
    chk = 1; prev = -1;
    n = tbl ? 4 : 6;
    for (int i = 0; i < n; i++) begin
      o = tbl ? shut_ofs[i] : run_ofs[i];
      tk = o * TD;
      p = ((chk > tk) ? chk : tk) + 1;
      chk = p + 1;
      q_code.push_back(tbl ? shut_code[i] : run_code[i]);
      q_time.push_back(timed ? t0 + p + 1 : -1);
      q_req.push_back((o == prev) ? "R3" : (tbl ? "R5" : "R2"));
      prev = o;
    end
  endtask

  task automatic pulse(input bit is_abort);
    @(negedge clk); #1;
    if (is_abort) abort = 1; else start = 1;
    t0 = ncnt;
    @(negedge clk); #1;
    abort = 0; start = 0;
  endtask

  task automatic drain();
    while (q_code.size() != 0 || busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !tx_push && !late && !in_shutdown, "R1 reset state",
          {busy, tx_push, late, in_shutdown}, 0);
    rst = 0;
    for (int i = 0; i < 6; i++) load(0, i, run_ofs[i], run_code[i]);
    load(0, 6, 0, 8'h00);
    for (int i = 0; i < 4; i++) load(1, i, shut_ofs[i], shut_code[i]);
    load(1, 4, 0, 8'h00);

    // A: plain run table
    pulse(0);
    expect_table(0, 1);
    check(busy && !in_shutdown, "R2 busy after start", {busy, in_shutdown}, 2);
    drain();
    check(!busy, "R4 busy falls at end", busy, 0);
    check(pushes == 6, "R4 push count", pushes, 6);

    // B: abort in mid-run, then ignored commands
    pulse(0);
    expect_table(0, 1);
    while (ncnt < t0 + 60) @(negedge clk);
    #1;
    check(q_code.size() == 3, "R2 rows before abort", q_code.size(), 3);
    q_code.delete(); q_time.delete(); q_req.delete();
    pulse(1);
    expect_table(1, 1);
    check(in_shutdown && busy, "R5 shutdown selected", {in_shutdown, busy}, 3);
    while (ncnt < t0 + 40) @(negedge clk);
    #1; start = 1;
    @(negedge clk); #1; start = 0; abort = 1;
    @(negedge clk); #1; abort = 0;
    check(in_shutdown, "R6 start ignored", in_shutdown, 1);
    drain();
    check(pushes == 13, "R5 no run rows after abort", pushes, 13);

    // C: FIFO full at launch
    link_en = 8'h5A;
    tx_full = 1;
    pulse(0);
    expect_table(0, 0);
    repeat (30) @(negedge clk);
    #1;
    check(pushes == 13, "R7 held while full", pushes, 13);
    check(late, "R7 late raised", late, 1);
    tx_full = 0;
    drain();
    check(late, "R7 late sticky", late, 1);
    check(pushes == 19, "R7 nothing lost", pushes, 19);

    // D: abort from idle clears late
    link_en = 8'h81;
    pulse(1);
    expect_table(1, 1);
    check(!late && in_shutdown, "R7 late cleared by launch", {late, in_shutdown}, 1);
    drain();
    check(pushes == 23 && !busy, "R4 shutdown end", pushes, 23);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end
endmodule